// File: doc/BRIEF.md
# Multi-Mode Variable-Count Shifter

This block shifts an N-bit operand by a variable count in one of five ways, selected by a 3-bit mode code. Two of the left modes are uncommon. The first fills the vacated low positions with copies of the operand's original bit 0 instead of zeros. The second keeps the sign bit fixed and moves only the bits below it. An overflow flag reports when a left shift of a two's-complement operand could not represent the true product operand × 2^count.

The shift logic is purely combinational. A parameter selects whether the result goes through an output register stage. When the register is fitted, the block captures a new result on each rising clock edge where `valid_in` is high. It then raises `valid_out` one cycle later and holds the result between accepted operations. Bit 0 is the least significant, rightmost position on both the operand and the result.

Top module: `varshift_unit`

## Requirements
- R1: Mode 000 (logical left) moves every bit up by the count. Positions below the count become 0 and the bits moved past bit N-1 are dropped. Bit 0 is the rightmost position.
- R2: Mode 001 (replicate left) moves bits up as in mode 000, but every vacated low position takes the value of the operand's original bit 0.
- R3: Mode 010 (sign-preserving left) copies operand bit N-1 to result bit N-1. Bits N-2..0 shift up by the count with zero fill, and bits moved past position N-2 are lost.
- R4: Mode 011 (logical right) moves bits down by the count and fills the vacated high positions with 0.
- R5: Mode 100 (arithmetic right) moves bits down by the count and fills the vacated high positions with operand bit N-1.
- R6: In modes 000 and 010, the overflow flag is set when the operand bits N-1 down to N-1-count are not all equal. When the count is N or more, the flag is set whenever the operand is nonzero. In every other mode the flag is 0.
- R7: A count of zero returns the operand unchanged with the overflow flag clear, in every mode.
- R8: A count of N or more gives full shift-out:
  - modes 000, 011 and 010 (below its kept sign bit) give zeros;
  - mode 001 gives all copies of bit 0;
  - mode 100 gives all copies of bit N-1.
- R9: Mode codes 101, 110 and 111 pass the operand through unchanged with the overflow flag clear.
- R10: With the register stage fitted, each accepted operation behaves as follows:
  - `valid_out` on each rising edge equals `valid_in` from the edge before;
  - `result` and `overflow` update only on edges where `valid_in` is high, and hold otherwise.
- R11: A rising edge with `rst_n` low clears `result`, `overflow` and `valid_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operand, count and mode are valid this cycle |
| operand | input | WIDTH | Value to shift |
| count | input | $clog2(WIDTH)+1 | Shift distance; values of WIDTH or more give full shift-out |
| mode | input | 3 | Shift mode code (000..100; other codes pass through) |
| result | output | WIDTH | Shifted value |
| overflow | output | 1 | Signed left shift lost significant bits |
| valid_out | output | 1 | Result is valid |

## Verification
The bench builds the block with WIDTH=16 and the register stage fitted. With these values the 5-bit count reaches 31, so counts from 16 to 31 exercise the saturation path alongside 0 through 15. The fitted register also brings the capture, hold and reset behaviour within reach. Seeded random stimulus covers all eight mode codes over the full count range. Directed cases cover:
- the operands 0, all ones, the most negative value and 1;
- counts of 0, N-1, N and the maximum, where the fill, sign and overflow rules meet.

// File: rtl/varshift_pkg.sv
// Shared types for the variable-count shifter.
// Assumes: mode codes are fixed at 3 bits; unlisted codes are pass-through.
package varshift_pkg;

    typedef enum logic [2:0] {
        SH_LSL = 3'b000,  // logical left, zero fill
        SH_LRP = 3'b001,  // left, fill with original bit 0
        SH_LSP = 3'b010,  // left below a fixed sign bit
        SH_LSR = 3'b011,  // logical right, zero fill
        SH_ASR = 3'b100   // arithmetic right, sign fill
    } shift_mode_e;

endpackage

// File: rtl/vs_left_unit.sv
// Left-shift datapath: computes all three left variants and the signed
// overflow condition in parallel.
// Assumes: COUNT_W can express values of WIDTH or more; any count of WIDTH
// or more means every original bit is shifted out.
module vs_left_unit #(
    parameter int WIDTH   = 16,
    parameter int COUNT_W = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0]   operand,
    input  logic [COUNT_W-1:0] count,
    output logic [WIDTH-1:0]   lsl_res,
    output logic [WIDTH-1:0]   lrp_res,
    output logic [WIDTH-1:0]   lsp_res,
    output logic               sgn_ovf
);

    localparam logic [WIDTH-1:0]   ALL_ONES = {WIDTH{1'b1}};
    localparam logic [COUNT_W-1:0] FULL_CNT = COUNT_W'(WIDTH);

    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] low_fill;
    logic [WIDTH-1:0] top_mask;
    logic [WIDTH-1:0] top_bits;
    logic [COUNT_W:0] cnt_plus1;
    logic             saturated;

    // Base shift and the mask of vacated low positions.
    always_comb begin
        shifted  = operand << count;
        low_fill = ~(ALL_ONES << count);
    end

    // Three left variants built from the base shift.
    always_comb begin
        lsl_res = shifted;
        lrp_res = shifted | (operand[0] ? low_fill : '0);
        lsp_res = {operand[WIDTH-1], shifted[WIDTH-2:0]};
    end

    // Overflow: the top count+1 bits must all equal the sign bit.
    always_comb begin
        saturated = (count >= FULL_CNT);
        cnt_plus1 = {1'b0, count} + 1'b1;
        top_mask  = ~(ALL_ONES >> cnt_plus1);
        top_bits  = operand & top_mask;
        if (saturated)
            sgn_ovf = |operand;
        else
            sgn_ovf = (top_bits != '0) && (top_bits != top_mask);
    end

endmodule

// File: rtl/vs_right_unit.sv
// Right-shift datapath: logical and arithmetic variants.
// Assumes: a count of WIDTH or more empties the word (zeros or sign copies).
module vs_right_unit #(
    parameter int WIDTH   = 16,
    parameter int COUNT_W = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0]   operand,
    input  logic [COUNT_W-1:0] count,
    output logic [WIDTH-1:0]   lsr_res,
    output logic [WIDTH-1:0]   asr_res
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] high_fill;

    // Logical shift plus a mask of vacated high positions for sign fill.
    always_comb begin
        lsr_res   = operand >> count;
        high_fill = ~(ALL_ONES >> count);
        asr_res   = lsr_res | (operand[WIDTH-1] ? high_fill : '0);
    end

endmodule

// File: rtl/vs_out_stage.sv
// Output stage: either a capture register gated by valid_in, or a straight
// wire, chosen by REGISTER_OUT.
// Assumes: reset is synchronous and active low.
module vs_out_stage #(
    parameter int WIDTH        = 16,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [WIDTH-1:0] res_d,
    input  logic             ovf_d,
    output logic [WIDTH-1:0] result,
    output logic             overflow,
    output logic             valid_out
);

    generate
        if (REGISTER_OUT) begin : g_reg
            logic [WIDTH-1:0] res_q;
            logic             ovf_q;
            logic             vld_q;

            // Capture on valid_in, hold otherwise, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q <= '0;
                    ovf_q <= 1'b0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= valid_in;
                    if (valid_in) begin
                        res_q <= res_d;
                        ovf_q <= ovf_d;
                    end
                end
            end

            assign result    = res_q;
            assign overflow  = ovf_q;
            assign valid_out = vld_q;
        end else begin : g_wire
            assign result    = res_d;
            assign overflow  = ovf_d;
            assign valid_out = valid_in;
        end
    endgenerate

endmodule

// File: rtl/varshift_unit.sv
// Top of the variable-count shifter: decodes the mode, selects one of the
// datapath results and the overflow flag, and feeds the output stage.
// Assumes: a count of zero must return the operand exactly; undefined mode
// codes pass the operand through.
module varshift_unit #(
    parameter int WIDTH        = 16,
    parameter bit REGISTER_OUT = 1'b1,
    localparam int COUNT_W     = $clog2(WIDTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [WIDTH-1:0]   operand,
    input  logic [COUNT_W-1:0] count,
    input  logic [2:0]         mode,
    output logic [WIDTH-1:0]   result,
    output logic               overflow,
    output logic               valid_out
);

    import varshift_pkg::*;

    logic [WIDTH-1:0] lsl_res, lrp_res, lsp_res, lsr_res, asr_res;
    logic             sgn_ovf;
    logic [WIDTH-1:0] sel_res;
    logic             sel_ovf;

    vs_left_unit #(.WIDTH(WIDTH), .COUNT_W(COUNT_W)) u_left (
        .operand (operand),
        .count   (count),
        .lsl_res (lsl_res),
        .lrp_res (lrp_res),
        .lsp_res (lsp_res),
        .sgn_ovf (sgn_ovf)
    );

    vs_right_unit #(.WIDTH(WIDTH), .COUNT_W(COUNT_W)) u_right (
        .operand (operand),
        .count   (count),
        .lsr_res (lsr_res),
        .asr_res (asr_res)
    );

    // Mode decode: pick the result and qualify overflow for signed-left modes.
    always_comb begin
        sel_ovf = 1'b0;
        case (shift_mode_e'(mode))
            SH_LSL: begin sel_res = lsl_res; sel_ovf = sgn_ovf; end
            SH_LRP: sel_res = lrp_res;
            SH_LSP: begin sel_res = lsp_res; sel_ovf = sgn_ovf; end
            SH_LSR: sel_res = lsr_res;
            SH_ASR: sel_res = asr_res;
            default: sel_res = operand;
        endcase
    end

    vs_out_stage #(.WIDTH(WIDTH), .REGISTER_OUT(REGISTER_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .res_d     (sel_res),
        .ovf_d     (sel_ovf),
        .result    (result),
        .overflow  (overflow),
        .valid_out (valid_out)
    );

endmodule

// File: rtl/varshift_chk.sv
// Checker for varshift_unit: temporal properties of the registered variant.
// Assumes: bound to every varshift_unit instance; idle when REGISTER_OUT=0.
module varshift_chk #(
    parameter int WIDTH        = 16,
    parameter bit REGISTER_OUT = 1'b1,
    parameter int COUNT_W      = $clog2(WIDTH) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid_in,
    input logic [WIDTH-1:0]   operand,
    input logic [COUNT_W-1:0] count,
    input logic [2:0]         mode,
    input logic [WIDTH-1:0]   result,
    input logic               overflow,
    input logic               valid_out
);

    generate
        if (REGISTER_OUT) begin : g_seq
            // R10
            valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                valid_in |=> valid_out);
            // R10
            valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> !valid_out);
            // R10
            hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> ($stable(result) && $stable(overflow)));
            // R7
            zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && count == '0) |=> (result == $past(operand) && !overflow));
            // R3
            sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && mode == 3'b010) |=> (result[WIDTH-1] == $past(operand[WIDTH-1])));
            // R9
            pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && mode > 3'b100) |=> (result == $past(operand) && !overflow));
            // R6
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && mode != 3'b000 && mode != 3'b010) |=> !overflow);
        end
    endgenerate

endmodule

bind varshift_unit varshift_chk #(
    .WIDTH(WIDTH), .REGISTER_OUT(REGISTER_OUT), .COUNT_W(COUNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .operand(operand),
    .count(count), .mode(mode), .result(result), .overflow(overflow),
    .valid_out(valid_out)
);

// File: tb/varshift_unit_tb.sv
`timescale 1ns/1ps
module varshift_unit_tb;

    localparam int WIDTH   = 16;
    localparam int COUNT_W = $clog2(WIDTH) + 1;
    localparam int NRAND   = 3000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               valid_in = 1'b0;
    logic [WIDTH-1:0]   operand = '0;
    logic [COUNT_W-1:0] count = '0;
    logic [2:0]         mode = '0;
    logic [WIDTH-1:0]   result;
    logic               overflow;
    logic               valid_out;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] last_res;
    logic             last_ovf;

    always #4 clk = ~clk;

    varshift_unit #(.WIDTH(WIDTH), .REGISTER_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .operand(operand),
        .count(count), .mode(mode), .result(result), .overflow(overflow),
        .valid_out(valid_out)
    );

    // Bit-by-bit reference result from the requirements.
    function automatic logic [WIDTH-1:0] ref_res(logic [WIDTH-1:0] op, int k, logic [2:0] md);
        logic [WIDTH-1:0] r;
        for (int i = 0; i < WIDTH; i++) begin
            case (md)
                3'd0: r[i] = (i - k >= 0) ? op[i-k] : 1'b0;
                3'd1: r[i] = (i - k >= 0) ? op[i-k] : op[0];
                3'd2: r[i] = (i == WIDTH-1) ? op[WIDTH-1] : ((i - k >= 0) ? op[i-k] : 1'b0);
                3'd3: r[i] = (i + k < WIDTH) ? op[i+k] : 1'b0;
                3'd4: r[i] = (i + k < WIDTH) ? op[i+k] : op[WIDTH-1];
                default: r[i] = op[i];
            endcase
        end
        return r;
    endfunction

    // Reference overflow flag.
    function automatic logic ref_ovf(logic [WIDTH-1:0] op, int k, logic [2:0] md);
        logic o = 1'b0;
        if (md != 3'd0 && md != 3'd2) return 1'b0;
        if (k >= WIDTH) return (op != '0);
        for (int j = WIDTH-1-k; j < WIDTH; j++)
            if (op[j] != op[WIDTH-1]) o = 1'b1;
        return o;
    endfunction

    function automatic string tag_of(int k, logic [2:0] md);
        if (k == 0) return "R7";
        if (md > 3'd4) return "R9";
        if (k >= WIDTH) return "R8";
        case (md)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one operation, wait for the register, compare at the negedge.
    task automatic run_op(logic [WIDTH-1:0] op, int k, logic [2:0] md);
        logic [WIDTH-1:0] er;
        logic             eo;
        @(negedge clk);
        operand  = op;
        count    = COUNT_W'(k);
        mode     = md;
        valid_in = 1'b1;
        er = ref_res(op, k, md);
        eo = ref_ovf(op, k, md);
        @(negedge clk);
        chk(tag_of(k, md), 32'(result), 32'(er));
        chk("R6", 32'(overflow), 32'(eo));
        chk("R10", 32'(valid_out), 32'd1);
        last_res = er;
        last_ovf = eo;
    endtask

    // Idle cycle with changed inputs: outputs must hold.
    task automatic idle_hold();
        @(negedge clk);
        valid_in = 1'b0;
        operand  = ~operand;
        mode     = 3'd0;
        count    = COUNT_W'(1);
        @(negedge clk);
        chk("R10", 32'(result), 32'(last_res));
        chk("R10", 32'(overflow), 32'(last_ovf));
        chk("R10", 32'(valid_out), 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [WIDTH-1:0] corners [5];
        int cnts [6];
        void'($urandom(32'd20240917));
        corners = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'h4001};
        cnts    = '{0, 1, WIDTH-1, WIDTH, WIDTH+3, (1 << COUNT_W) - 1};

        // R11: reset clears everything even with valid_in high
        valid_in = 1'b1;
        operand  = 16'hBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", 32'(result), 32'd0);
        chk("R11", 32'(overflow), 32'd0);
        chk("R11", 32'(valid_out), 32'd0);
        rst_n    = 1'b1;
        valid_in = 1'b0;

        // Directed corners: every mode code, edge counts, edge operands
        for (int m = 0; m < 8; m++)
            foreach (corners[c])
                foreach (cnts[n])
                    run_op(corners[c], cnts[n], 3'(m));

        // R6: specific overflow cases in the signed left modes
        run_op(16'h4000, 1, 3'd0);   // sign flips: overflow
        chk("R6", 32'(overflow), 32'd1);
        run_op(16'hFFFF, WIDTH-1, 3'd2); // -1 << 15 fits
        chk("R6", 32'(overflow), 32'd0);
        run_op(16'h2000, 2, 3'd2);   // lost bit under kept sign
        chk("R6", 32'(overflow), 32'd1);
        chk("R3", 32'(result), 32'h0000);
        idle_hold();

        // Random mix with occasional idle cycles
        for (int i = 0; i < NRAND; i++) begin
            run_op(WIDTH'($urandom), int'($urandom_range(0, (1 << COUNT_W) - 1)),
                   3'($urandom_range(0, 7)));
            if ($urandom_range(0, 9) == 0) idle_hold();
        end

        // R11: reset in mid-run
        @(negedge clk);
        rst_n    = 1'b0;
        valid_in = 1'b1;
        @(negedge clk);
        chk("R11", 32'(result), 32'd0);
        chk("R11", 32'(valid_out), 32'd0);
        rst_n    = 1'b1;
        valid_in = 1'b0;
        run_op(16'h0003, 4, 3'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule